// File: doc/BRIEF.md
# I2C Control and Status Slave for a Dual-Output AV Router

This block is the serial register front end of a routing switch that feeds two audio/video outputs. It watches the two I2C lines on a fast system clock and cleans them up. It recognises its own 7-bit address, which one strap pin sets. It pulls SDA low through an output enable and never drives the line high. The clock line is only sampled, and the block never stretches it.

A write carries two data bytes after the address. The first byte sets the routing word for output 1 and the second sets the word for output 2. Both words go out as plain parallel buses to the routing logic. In each word, bit 7 picks the audio gain, bits 6..3 pick the video source and bits 2..0 pick the audio source. A read returns one status byte. That byte holds a one-shot power-up flag and the decoded state of two three-level sense pins. The level comparators are outside this block, and each pin reaches it as a two-bit code.

There is no stream interface on this block. The I2C master sets the pace of every transfer, and the block can neither stall nor refuse one. The only exception is that it does not acknowledge an address that is not its own. All other pins are plain levels.

Top module: `avsw_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 100100 followed by the value of `addr_sel_i`. With the strap low, this means 0x90 for a write and 0x91 for a read. With the strap high, it means 0x92 for a write and 0x93 for a read.
- R2: After an address byte that does not match, the block does not acknowledge. It then leaves SDA released and ignores all bus traffic until the next start condition.
- R3: In a write, bits arrive MSB first. The first data byte loads `ctrl1_o` and the second loads `ctrl2_o`. The block acknowledges each of these bytes.
- R4: Data bytes after the second in a write are acknowledged but change neither control output.
- R5: After `rst_n` is released, `ctrl1_o` and `ctrl2_o` are zero, the power-up flag is 1 and `sda_oe_o` is 0.
- R6: The status byte is laid out as follows: bit 7 is the power-up flag, bit 6 is open for sense pin 1, bit 5 is select for sense pin 1, bit 4 is open for sense pin 2, bit 3 is select for sense pin 2, and bits 2..0 are 0. It is sent MSB first.
- R7: Each two-bit level code maps to an (open, select) pair as follows: 00 (low) gives (0,1), 01 (mid) gives (0,0), 10 (high) gives (1,0), and 11 reads as mid (0,0).
- R8: The first status read after reset returns the power-up flag as 1. The flag is cleared once that read is acknowledged, so every later read returns 0.
- R9: After the status byte, the block releases SDA for the master's acknowledge slot and returns to idle. `sda_oe_o` is asserted only while an acknowledge bit or a 0 data bit is being driven.
- R10: A repeated start restarts address decoding. A stop or repeated start in the middle of a write keeps every control byte that was already complete.
- R11: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks after synchronisation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| addr_sel_i | input | 1 | Address strap; the least significant address bit |
| s1_level_i | input | 2 | Level code of sense pin 1 (00 low, 01 mid, 10 high) |
| s2_level_i | input | 2 | Level code of sense pin 2 (same encoding) |
| ctrl1_o | output | 8 | Routing word for output 1 |
| ctrl2_o | output | 8 | Routing word for output 2 |

## Verification
The assertions make several assumptions about the inputs:
- Outside start and stop conditions, SDA changes only while SCL is low.
- Every SCL phase lasts well beyond the synchroniser delay plus `FILT_LEN` clocks.
- The strap and the level codes do not change during a transaction.

The bench master keeps within these rules by using quarter-bit phases of 16 clocks. It changes SDA only in the low phase, except when it builds a start or a stop. The one deliberate breach is a single-clock SCL dip inside a high phase, which exercises the filter.

// File: rtl/avsw_i2c_pkg.sv
package avsw_i2c_pkg;
  localparam int BYTE_BITS = 8;
  localparam int CNT_W     = $clog2(BYTE_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } slv_state_t;

  typedef enum logic [1:0] {
    LVL_LOW = 2'b00, LVL_MID = 2'b01, LVL_HIGH = 2'b10, LVL_SPARE = 2'b11
  } lvl_code_t;

  typedef struct packed {
    logic open;
    logic sel;
  } pin_flags_t;
endpackage

// File: rtl/avsw_line_filter.sv
module avsw_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == filt_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assign line_o = filt_q;

  // R11: the clean line only moves after the synchronised line disagreed with it
  a_r11_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) != $past(filt_q)));
endmodule

// File: rtl/avsw_level_decode.sv
module avsw_level_decode
  import avsw_i2c_pkg::*;
(
  input  logic [1:0] code_i,
  output pin_flags_t flags_o
);
  always_comb begin
    unique case (lvl_code_t'(code_i))
      LVL_LOW:  flags_o = '{open: 1'b0, sel: 1'b1};
      LVL_HIGH: flags_o = '{open: 1'b1, sel: 1'b0};
      default:  flags_o = '{open: 1'b0, sel: 1'b0};
    endcase
  end

  // R7: a pin can never read as both open and selected
  always_comb begin
    a_r7_not_both: assert (!(flags_o.open && flags_o.sel));
  end
endmodule

// File: rtl/avsw_i2c_slave.sv
module avsw_i2c_slave
  import avsw_i2c_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter logic [5:0] ADDR_HI  = 6'b100100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       addr_sel_i,
  input  logic [1:0] s1_level_i,
  input  logic [1:0] s2_level_i,
  output logic [7:0] ctrl1_o,
  output logic [7:0] ctrl2_o
);
  localparam int N_LINES = 2;
  localparam int N_PINS  = 2;

  // ---- line conditioning: index 0 = SCL, 1 = SDA
  logic [N_LINES-1:0] raw_lines, clean_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    avsw_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  // ---- three-level sense pins
  logic [1:0] lvl_codes [N_PINS];
  pin_flags_t pin_flags [N_PINS];
  assign lvl_codes[0] = s1_level_i;
  assign lvl_codes[1] = s2_level_i;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    avsw_level_decode i_dec (
      .code_i  (lvl_codes[p]),
      .flags_o (pin_flags[p])
    );
  end

  // ---- bus events
  logic scl_f, sda_f, scl_d, sda_d;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_f    = clean_lines[0];
  assign sda_f    = clean_lines[1];
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;

  // ---- byte engine
  slv_state_t       state_q;
  logic [CNT_W-1:0] bit_q;
  logic [7:0]       sh_q, tx_q;
  logic             oe_q, rw_q, pon_q;
  logic [1:0]       widx_q;
  logic [7:0]       status_byte;
  logic             own_addr, byte_full;

  assign status_byte = {pon_q, pin_flags[0].open, pin_flags[0].sel,
                        pin_flags[1].open, pin_flags[1].sel, 3'b000};
  assign own_addr    = (sh_q[7:1] == {ADDR_HI, addr_sel_i});
  assign byte_full   = (bit_q == CNT_W'(BYTE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      pon_q   <= 1'b1;
      widx_q  <= '0;
      ctrl1_o <= '0;
      ctrl2_o <= '0;
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      if (start_ev) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              bit_q <= bit_q + CNT_W'(1);
            end else if (scl_fall && byte_full) begin
              if (own_addr) begin
                oe_q    <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (rw_q) begin
                tx_q    <= status_byte;
                oe_q    <= ~status_byte[7];
                pon_q   <= 1'b0;
                state_q <= ST_RD;
              end else begin
                oe_q    <= 1'b0;
                widx_q  <= '0;
                state_q <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              bit_q <= bit_q + CNT_W'(1);
            end else if (scl_fall && byte_full) begin
              oe_q    <= 1'b1;
              state_q <= ST_WACK;
              if (widx_q == 2'd0) ctrl1_o <= sh_q;
              else if (widx_q == 2'd1) ctrl2_o <= sh_q;
              if (widx_q != 2'd2) widx_q <= widx_q + 2'd1;
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              bit_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bit_q <= bit_q + CNT_W'(1);
            end else if (scl_fall) begin
              if (byte_full) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                tx_q <= {tx_q[6:0], 1'b0};
                oe_q <= ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_fall) state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  // R2 / R5: nothing is driven while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);

  // R2: a foreign address ends in idle without an acknowledge
  a_r2_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && !start_ev && !stop_ev && scl_fall && byte_full && !own_addr)
      |=> (state_q == ST_IDLE && !sda_oe_o));

  // R3: routing words only move during a write data phase
  a_r3_ctrl_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_WR) |=> ($stable(ctrl1_o) && $stable(ctrl2_o)));

  // R4: once two bytes are taken, further bytes leave both words alone
  a_r4_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (widx_q == 2'd2) |=> ($stable(ctrl1_o) && $stable(ctrl2_o)));

  // R8: the power-up flag never comes back once cleared
  a_r8_pon_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !pon_q |=> !pon_q);

  // R9: a stop always releases the data line
  a_r9_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe_o);

  // R9: SDA is pulled only in acknowledge or read-data states
  a_r9_drive_states: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (state_q inside {ST_AACK, ST_WACK, ST_RD}));
endmodule

// File: tb/test_avsw_i2c_slave.sv
module test_avsw_i2c_slave;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic strap = 1'b0;
  logic [1:0] lvl1 = 2'b00, lvl2 = 2'b00;
  logic sda_oe;
  logic sda_line;
  logic [7:0] ctrl1, ctrl2;

  always #2.5 clk = ~clk;

  assign sda_line = !(m_sda_low || sda_oe);

  avsw_i2c_slave i_avsw_i2c_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (m_scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .addr_sel_i (strap),
    .s1_level_i (lvl1),
    .s2_level_i (lvl2),
    .ctrl1_o    (ctrl1),
    .ctrl2_o    (ctrl2)
  );

  // ---- scoreboard
  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_val;
  event       obs_ev;
  bit         done = 0;

  task automatic expect_item(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_val = v;
    ->obs_ev;
    #1;
  endtask

  initial begin
    forever begin
      @(obs_ev);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected item actual=%02h expected=none", obs_val);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (obs_val !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, obs_val, e);
        end
      end
    end
  end

  // ---- bus master
  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; waitq();
    m_scl = 1'b1;     waitq();
    m_sda_low = 1'b1; waitq();
    m_scl = 1'b0;     waitq();
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; waitq();
    m_scl = 1'b1;     waitq();
    m_sda_low = 1'b0; waitq();
  endtask

  task automatic send_bit(input logic b, input bit glitch);
    m_sda_low = !b; waitq();
    m_scl = 1'b1;   waitq();
    if (glitch) begin
      @(negedge clk) m_scl = 1'b0;
      @(negedge clk) m_scl = 1'b1;
    end
    waitq();
    m_scl = 1'b0;   waitq();
  endtask

  task automatic write_byte(input logic [7:0] b, input int glitch_bit, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == glitch_bit));
    m_sda_low = 1'b0; waitq();
    m_scl = 1'b1;     waitq();
    ack_n = sda_line; waitq();
    m_scl = 1'b0;     waitq();
  endtask

  task automatic read_byte(output logic [7:0] v);
    v = '0;
    m_sda_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      waitq();
      m_scl = 1'b1; waitq();
      v = {v[6:0], sda_line}; waitq();
      m_scl = 1'b0; waitq();
    end
  endtask

  // read one status byte, NAK it and check the line is released
  task automatic status_read(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    logic a; logic [7:0] d;
    bus_start();
    expect_item("R1 read address ack", 8'h00);
    write_byte(addr, -1, a); observe({7'd0, a});
    read_byte(d);
    expect_item(tag, exp); observe(d);
    send_bit(1'b1, 1'b0);
    waitq();
    expect_item("R9 released after status", 8'h00); observe({7'd0, sda_oe});
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R5 reset state
    expect_item("R5 ctrl1 reset", 8'h00); observe(ctrl1);
    expect_item("R5 ctrl2 reset", 8'h00); observe(ctrl2);
    expect_item("R5 sda released", 8'h00); observe({7'd0, sda_oe});

    // R6 R7 R8: first read, s1 low -> (0,1), s2 high -> (1,0), flag 1
    lvl1 = 2'b00; lvl2 = 2'b10;
    status_read(8'h91, 8'hB0, "R8 R6 first status");

    // R8 R7: second read, s1 mid -> (0,0), s2 low -> (0,1), flag now 0
    lvl1 = 2'b01; lvl2 = 2'b00;
    status_read(8'h91, 8'h08, "R8 R7 second status");

    // R3: two-byte write
    bus_start();
    expect_item("R1 write address ack", 8'h00); write_byte(8'h90, -1, a); observe({7'd0, a});
    expect_item("R3 byte1 ack", 8'h00); write_byte(8'hA5, -1, a); observe({7'd0, a});
    expect_item("R3 byte2 ack", 8'h00); write_byte(8'h3C, -1, a); observe({7'd0, a});
    bus_stop();
    expect_item("R3 ctrl1", 8'hA5); observe(ctrl1);
    expect_item("R3 ctrl2", 8'h3C); observe(ctrl2);

    // R4: extra bytes acknowledged and dropped
    bus_start();
    write_byte(8'h90, -1, a);
    write_byte(8'h11, -1, a);
    write_byte(8'h22, -1, a);
    expect_item("R4 extra byte ack", 8'h00); write_byte(8'h77, -1, a); observe({7'd0, a});
    write_byte(8'h88, -1, a);
    bus_stop();
    expect_item("R4 ctrl1 kept", 8'h11); observe(ctrl1);
    expect_item("R4 ctrl2 kept", 8'h22); observe(ctrl2);

    // R2: foreign address with strap low
    bus_start();
    expect_item("R2 foreign address nak", 8'h01); write_byte(8'h92, -1, a); observe({7'd0, a});
    expect_item("R2 following byte nak", 8'h01); write_byte(8'h55, -1, a); observe({7'd0, a});
    bus_stop();
    expect_item("R2 ctrl1 untouched", 8'h11); observe(ctrl1);

    // R1: strap high moves the address
    strap = 1'b1;
    repeat (4) @(negedge clk);
    bus_start();
    expect_item("R1 old read address nak", 8'h01); write_byte(8'h91, -1, a); observe({7'd0, a});
    bus_stop();
    bus_start();
    expect_item("R1 strap-high write ack", 8'h00); write_byte(8'h92, -1, a); observe({7'd0, a});
    write_byte(8'h5A, -1, a);
    write_byte(8'hC3, -1, a);
    bus_stop();
    expect_item("R1 ctrl1 strap high", 8'h5A); observe(ctrl1);
    expect_item("R1 ctrl2 strap high", 8'hC3); observe(ctrl2);

    // R10: repeated start after one byte, then a read
    lvl1 = 2'b10; lvl2 = 2'b01;
    bus_start();
    write_byte(8'h92, -1, a);
    write_byte(8'h01, -1, a);
    status_read(8'h93, 8'h40, "R10 read after repeated start");
    expect_item("R10 ctrl1 kept before restart", 8'h01); observe(ctrl1);
    expect_item("R10 ctrl2 unchanged", 8'hC3); observe(ctrl2);

    // R10: stop after one byte
    bus_start();
    write_byte(8'h92, -1, a);
    write_byte(8'h66, -1, a);
    bus_stop();
    expect_item("R10 ctrl1 after early stop", 8'h66); observe(ctrl1);
    expect_item("R10 ctrl2 after early stop", 8'hC3); observe(ctrl2);

    // R11: one-clock SCL dip inside a high phase
    bus_start();
    write_byte(8'h92, -1, a);
    expect_item("R11 glitched byte ack", 8'h00); write_byte(8'hF0, 6, a); observe({7'd0, a});
    bus_stop();
    expect_item("R11 ctrl1 glitch rejected", 8'hF0); observe(ctrl1);

    // R7: spare code 11 reads as mid
    lvl1 = 2'b11; lvl2 = 2'b11;
    status_read(8'h93, 8'h00, "R7 spare code as mid");

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule